// File: doc/BRIEF.md
# Serial Audio Control Register Bank

This block is a receive-only two-wire bus target that holds the settings of a stereo audio signal path. It samples the bus clock and data lines with the system clock. It recognises bus start and stop conditions and accepts only the write address `0x88`. After the address it takes a function-select byte, then any number of data bytes, and drives the acknowledge low for every byte that belongs to it.

The function-select byte names one of eight setting slots and a stepping mode. The slots are source select, source gain, master level, low-band tone, a reserved slot, high-band tone, and the two per-channel output attenuators. The mode is either "keep writing the same slot" or "advance after every byte". Every setting is presented as a parallel output for the analog control circuits. From reset, each setting holds a fixed, non-zero listening default.

Top module: `audCfgTarget`

## Requirements
- R1: After reset the outputs are `srcSel`=2'b10, `srcGain`=4'b1110, `masterLvl`=7'b1111000, `toneLow`=4'b0111, `toneHigh`=4'b1110, `attnRight`=7'h7F and `attnLeft`=7'h7F, and `sdaPullLow`=0.
- R2: A start (SDA falling while SCL is high) restarts reception at the address byte from any state. After a stop (SDA rising while SCL is high), bytes clocked without a new start are neither acknowledged nor stored.
- R3: A first byte of exactly 0x88 is acknowledged, and so is every function-select and data byte that follows it. To acknowledge, the block holds SDA low through the ninth SCL pulse of the byte. Bytes are received MSB first.
- R4: Any other first byte gets no acknowledge, and the following bytes are ignored until the next start. None of them is acknowledged and no setting changes.
- R5: In the function-select byte, bits 3..0 choose the slot and bit 4 selects stepping; bits 7..5 have no effect. The slots are 0 source select, 1 source gain, 2 master level, 3 low tone, 4 reserved, 5 high tone, 6 right attenuator and 7 left attenuator.
- R6: With bit 4 clear, every data byte up to the stop goes to the same slot, and the last one wins.
- R7: With bit 4 set, each data byte goes to the current slot and the slot number then grows by one, wrapping from 15 to 0. Bytes aimed at slots 8 to 15 are acknowledged and dropped.
- R8: A byte aimed at slot 4 is acknowledged and uses up one step of the sequence, but it changes no output.
- R9: A stored setting takes the low bits of its data byte: 2 bits for source select, 4 bits for gain and both tone slots, and 7 bits for master level and both attenuators.
- R10: SDA is only ever pulled low or released (open drain), and the pull changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| srcSel | output | 2 | Source select setting |
| srcGain | output | 4 | Source gain setting |
| masterLvl | output | 7 | Master level setting |
| toneLow | output | 4 | Low-band tone setting |
| toneHigh | output | 4 | High-band tone setting |
| attnRight | output | 7 | Right output attenuator |
| attnLeft | output | 7 | Left output attenuator |

## Verification
Seeded random transfers mix function-select values, stepping modes, don't-care high bits and burst lengths. A register model separates a missed write, a wrong target slot and a wrong mask width. Directed cases cover the stepping wrap from slot 14 through 15 into 0 and 1, which shows whether dropped slots are skipped or stored. A burst across the reserved slot shows whether a step is lost or gained there. A repeated write to one slot shows that the slot does not advance when stepping is off. A foreign address and bytes clocked after a stop show that the block stays silent and leaves the settings alone until a new start.

// File: rtl/audCfgPkg.sv
package audCfgPkg;
  localparam int SLOT_COUNT = 8;
  localparam int IDX_W      = 4;
  localparam int DATA_W     = 7;
  localparam int BYTE_W     = 8;
  localparam int RSVD_SLOT  = 4;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [DATA_W-1:0] wrData;
  } cfgStrobe_t;

  function automatic int slotWidth(input int idx);
    case (idx)
      0:       return 2;
      1, 3, 5: return 4;
      2, 6, 7: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slotReset(input int idx);
    case (idx)
      0:       return 7'b0000010;
      1:       return 7'b0001110;
      2:       return 7'b1111000;
      3:       return 7'b0000111;
      5:       return 7'b0001110;
      6, 7:    return 7'b1111111;
      default: return 7'b0000000;
    endcase
  endfunction
endpackage

// File: rtl/audCfgBusCtrl.sv
module audCfgBusCtrl
  import audCfgPkg::*;
#(
  parameter logic [BYTE_W-1:0] CHIP_ADDR   = 8'h88,
  parameter int                SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output cfgStrobe_t stb
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_SUB, ST_DATA} busState_t;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic                   sclS, sdaS, sclP, sdaP;
  logic                   sclRise, sclFall, startDet, stopDet;
  busState_t              state;
  logic [CNT_W-1:0]       bitCnt;
  logic [BYTE_W-1:0]      shReg;
  logic                   inAck, sdaDrv, autoInc;
  logic [IDX_W-1:0]       subPtr;

  // two-stage synchronisers, idle-high at reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      shReg   <= '0;
      inAck   <= 1'b0;
      sdaDrv  <= 1'b0;
      autoInc <= 1'b0;
      subPtr  <= '0;
      stb     <= '0;
    end else begin
      stb.wrEn <= 1'b0;
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        inAck  <= 1'b0;
        sdaDrv <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        inAck  <= 1'b0;
        sdaDrv <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise && !inAck && bitCnt < CNT_W'(BYTE_W)) begin
          shReg  <= {shReg[BYTE_W-2:0], sdaS};
          bitCnt <= bitCnt + 1'b1;
        end
        if (sclFall) begin
          if (inAck) begin
            inAck  <= 1'b0;
            sdaDrv <= 1'b0;
            bitCnt <= '0;
          end else if (bitCnt == CNT_W'(BYTE_W)) begin
            inAck <= 1'b1;
            case (state)
              ST_ADDR: begin
                if (shReg == CHIP_ADDR) begin
                  sdaDrv <= 1'b1;
                  state  <= ST_SUB;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_SUB: begin
                subPtr  <= shReg[IDX_W-1:0];
                autoInc <= shReg[IDX_W];
                sdaDrv  <= 1'b1;
                state   <= ST_DATA;
              end
              default: begin
                sdaDrv     <= 1'b1;
                stb.wrEn   <= 1'b1;
                stb.wrIdx  <= subPtr;
                stb.wrData <= shReg[DATA_W-1:0];
                if (autoInc) subPtr <= subPtr + 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  assign sdaPullLow = sdaDrv;

  // R10
  pull_while_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrv) |-> !sclS);
  // R3
  write_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> sdaDrv);
  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!sdaDrv && !stb.wrEn));
  // R4
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !startDet) |=> (!sdaDrv && !stb.wrEn));
endmodule

// File: rtl/audCfgRegBank.sv
module audCfgRegBank
  import audCfgPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t stb,
  output logic [1:0] srcSel,
  output logic [3:0] srcGain,
  output logic [6:0] masterLvl,
  output logic [3:0] toneLow,
  output logic [3:0] toneHigh,
  output logic [6:0] attnRight,
  output logic [6:0] attnLeft
);
  for (genvar i = 0; i < SLOT_COUNT; i++) begin : gSlot
    if (i != RSVD_SLOT) begin : gReg
      localparam int              W  = slotWidth(i);
      localparam logic [DATA_W-1:0] RV = slotReset(i);
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= RV[W-1:0];
        else if (stb.wrEn && stb.wrIdx == IDX_W'(i)) q <= stb.wrData[W-1:0];
      end
    end
  end

  assign srcSel    = gSlot[0].gReg.q;
  assign srcGain   = gSlot[1].gReg.q;
  assign masterLvl = gSlot[2].gReg.q;
  assign toneLow   = gSlot[3].gReg.q;
  assign toneHigh  = gSlot[5].gReg.q;
  assign attnRight = gSlot[6].gReg.q;
  assign attnLeft  = gSlot[7].gReg.q;

  logic [34:0] allSettings;
  assign allSettings = {srcSel, srcGain, masterLvl, toneLow, toneHigh, attnRight, attnLeft};

  // R8
  dropped_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && (stb.wrIdx == IDX_W'(RSVD_SLOT) || stb.wrIdx[IDX_W-1])) |=> $stable(allSettings));
  // R6
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> $stable(allSettings));
endmodule

// File: rtl/audCfgTarget.sv
module audCfgTarget
  import audCfgPkg::*;
#(
  parameter logic [7:0] CHIP_ADDR   = 8'h88,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic [1:0] srcSel,
  output logic [3:0] srcGain,
  output logic [6:0] masterLvl,
  output logic [3:0] toneLow,
  output logic [3:0] toneHigh,
  output logic [6:0] attnRight,
  output logic [6:0] attnLeft
);
  cfgStrobe_t stb;

  audCfgBusCtrl #(.CHIP_ADDR(CHIP_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaPullLow(sdaPullLow), .stb(stb)
  );

  audCfgRegBank u_bank (
    .clk(clk), .rstN(rstN), .stb(stb),
    .srcSel(srcSel), .srcGain(srcGain), .masterLvl(masterLvl),
    .toneLow(toneLow), .toneHigh(toneHigh),
    .attnRight(attnRight), .attnLeft(attnLeft)
  );
endmodule

// File: tb/audCfgTarget_tb.sv
module audCfgTarget_tb;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullLow;
  logic [1:0] srcSel;
  logic [3:0] srcGain, toneLow, toneHigh;
  logic [6:0] masterLvl, attnRight, attnLeft;

  int total = 0, bad = 0, pullViol = 0;
  logic [6:0] model [8];
  logic prevPull = 1'b0;

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  audCfgTarget u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .srcSel(srcSel), .srcGain(srcGain),
    .masterLvl(masterLvl), .toneLow(toneLow), .toneHigh(toneHigh),
    .attnRight(attnRight), .attnLeft(attnLeft)
  );

  // R10: pull may only change while SCL is low
  always @(negedge clk) begin
    if (rstN && sdaPullLow !== prevPull && sclM === 1'b1) pullViol++;
    prevPull <= sdaPullLow;
  end

  function automatic logic [6:0] maskOf(input int idx);
    case (idx)
      0:       return 7'h03;
      1, 3, 5: return 7'h0F;
      2, 6, 7: return 7'h7F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    @(negedge clk);
    check(req, 32'(srcSel),    32'(model[0]));
    check(req, 32'(srcGain),   32'(model[1]));
    check(req, 32'(masterLvl), 32'(model[2]));
    check(req, 32'(toneLow),   32'(model[3]));
    check(req, 32'(toneHigh),  32'(model[5]));
    check(req, 32'(attnRight), 32'(model[6]));
    check(req, 32'(attnLeft),  32'(model[7]));
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      sdaM = b[k]; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    ack = (sdaLine == 1'b0);
    waitQ(); sclM = 1'b0; waitQ();
  endtask

  // full write transfer: address, function byte, data bytes; model updated per R5-R9
  task automatic writeTxn(input logic [7:0] sub, input int len, input logic [7:0] d [8], input string req);
    logic ack;
    logic [3:0] ptr;
    busStart();
    sendByte(8'h88, ack); check("R3 addr ack", 32'(ack), 1);
    sendByte(sub, ack);   check("R3 sub ack", 32'(ack), 1);
    ptr = sub[3:0];
    for (int n = 0; n < len; n++) begin
      sendByte(d[n], ack); check("R7 data ack", 32'(ack), 1);
      if (ptr < 8 && ptr != 4) model[ptr] = d[n][6:0] & maskOf(int'(ptr));
      if (sub[4]) ptr = ptr + 1'b1;
    end
    busStop();
    checkAll(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d [8];
    logic ack;
    void'($urandom(32'h5EED_1234));
    model[0] = 7'b0000010; model[1] = 7'b0001110; model[2] = 7'b1111000;
    model[3] = 7'b0000111; model[4] = 7'h00;      model[5] = 7'b0001110;
    model[6] = 7'h7F;      model[7] = 7'h7F;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset defaults
    checkAll("R1 reset");
    check("R1 pull idle", 32'(sdaPullLow), 0);

    // R6: no stepping, last byte wins in master level
    d[0] = 8'h15; d[1] = 8'h33; d[2] = 8'hA9;
    writeTxn(8'h02, 3, d, "R6 repeat slot");

    // R5: high bits of function byte ignored, high tone, no stepping
    d[0] = 8'hF3; d[1] = 8'h09;
    writeTxn(8'hE5, 2, d, "R5 dont care bits");

    // R8: stepping across reserved slot 4
    d[0] = 8'h0A; d[1] = 8'h55; d[2] = 8'h02;
    writeTxn(8'h13, 3, d, "R8 reserved slot");

    // R7: wrap from 14 through 15 to 0 and 1, dropped slots 14/15
    d[0] = 8'hFF; d[1] = 8'hFF; d[2] = 8'h01; d[3] = 8'h04;
    writeTxn(8'h1E, 4, d, "R7 wrap");

    // R9: widths, all slots with stepping from 0
    for (int n = 0; n < 8; n++) d[n] = 8'hFF;
    writeTxn(8'h10, 8, d, "R9 widths");

    // R4: foreign address, no ack, following bytes ignored
    busStart();
    sendByte(8'h8A, ack); check("R4 addr nack", 32'(ack), 0);
    sendByte(8'h12, ack); check("R4 sub ignored", 32'(ack), 0);
    sendByte(8'h00, ack); check("R4 data ignored", 32'(ack), 0);
    busStop();
    checkAll("R4 no change");

    // R2: bytes after stop without a start are ignored
    sendByte(8'h88, ack); check("R2 no ack after stop", 32'(ack), 0);
    sendByte(8'h02, ack); check("R2 no ack after stop", 32'(ack), 0);
    busStop();
    checkAll("R2 no change");

    // R2: start restarts at the address byte mid-transfer
    busStart();
    sendByte(8'h88, ack);
    sendByte(8'h01, ack);
    d[0] = 8'h03;
    writeTxn(8'h01, 1, d, "R2 restart");

    // random transfers
    for (int t = 0; t < 30; t++) begin
      logic [7:0] sub;
      int len;
      sub = 8'($urandom);
      len = 1 + int'($urandom % 5);
      for (int n = 0; n < 8; n++) d[n] = 8'($urandom);
      writeTxn(sub, len, d, "R7 random");
    end

    check("R10 pull only with SCL low", 32'(pullViol), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule